// File: doc/BRIEF.md
# SD card SPI-mode command engine

The engine issues one SD-card command over SPI and gathers the card's reply. A host hands it a 6-bit command index, a 32-bit argument, a flag marking an application-specific command, and a response class. The engine then works through each stage in turn. It polls the card until the card is ready. It sends the application prefix when one is needed, then the six-byte command frame. For a stop command it drops one stuff byte. It then scans for the one-byte R1 reply, retrying when no reply arrives. Depending on the class, it reads a 4-byte trailer or waits out a busy period. Last, it either releases chip select or keeps it asserted for a data phase that follows.

Every byte moves through a one-byte exchange port to an external bit shifter. The engine offers a byte with `xchg_valid` and `xchg_tx`, and it keeps both steady until the shifter raises `xchg_ready`. The received byte on `xchg_rx` is taken in that same cycle. The shifter may stall for any number of cycles; the engine simply waits. Requests use the same rule: `req_ready` is high only while the engine is idle, and a request is taken in the cycle where `req_valid` and `req_ready` are both high.

Top module: `sdc_cmd_engine`

## Requirements
- R1: The command frame is six bytes, sent in this order: `0x40 | index`, then argument bits 31:24, 23:16, 15:8 and 7:0, then a closing byte.
- R2: The closing byte is 0x95 for index 0 and 0x87 for index 8. For every other index, CMD55 included, it is 0xFF.
- R3: After the frame, the engine sends up to POLL_MAX (16) fill bytes of 0xFF. The first received byte with bit 7 clear becomes the R1 result. Received bytes with bit 7 set are skipped. If no byte qualifies, the R1 result is 0xFF.
- R4: When an attempt ends with R1 = 0xFF, the attempt is repeated from its frame (prefix included). There are at most RETRIES (3) attempts in total, and no ready-wait is inserted between them.
- R5: An application command (`req_app`=1) is preceded by a CMD55 frame with argument 0. The engine polls for that frame's reply and then runs a ready-wait before it sends the main frame. The CMD55 reply does not appear on the outputs.
- R6: For every index except 12, the engine first sends fill bytes until it receives 0xFF, or until READY_POLLS bytes have gone by. It then proceeds in either case.
- R7: For index 12, no ready-wait takes place. The byte received right after the frame is discarded, even when its bit 7 is clear.
- R8: `rsp_status` reports the first matching case, in this order of priority: 1 = no reply (R1 = 0xFF), 2 = bit 3 set, 3 = bit 2 set, 4 = bit 1 or bit 4 set, 5 = bit 5 or bit 6 set, otherwise 0. After codes 1, 2 or 3, no trailer or busy bytes are exchanged.
- R9: With `req_rtype` 2 or 3, the engine reads four more bytes and places them in `rsp_word`, most significant byte first. With any other type, `rsp_word` is 0.
- R10: With `req_rtype` 1, the engine sends fill bytes until it receives 0xFF, or until BUSY_POLLS bytes have gone by. Type 0 reads R1 only.
- R11: `cs_n` goes low when a request is accepted. It stays low after `done` when the status is 0 and the command is index 9, 17, 18, 24 or 25 without the prefix, or index 22 with it. In every other case `cs_n` goes high, and one more 0xFF byte is exchanged with `cs_n` high before `done`.
- R12: Every byte sent outside the frame is 0xFF. `xchg_tx` and `xchg_valid` do not change while a byte is pending.
- R13: `done` is a single-cycle pulse. `req_ready` is high only when no byte is pending. The result outputs hold their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_idx | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_app | input | 1 | Prefix with CMD55 |
| req_rtype | input | 2 | 0 R1, 1 R1 with busy, 2 R3, 3 R7 |
| xchg_valid | output | 1 | Byte offered to shifter |
| xchg_ready | input | 1 | Shifter completes exchange this cycle |
| xchg_tx | output | 8 | Byte to send |
| xchg_rx | input | 8 | Byte received, valid with xchg_ready |
| cs_n | output | 1 | Card chip select, active low |
| done | output | 1 | Result pulse |
| rsp_r1 | output | 8 | R1 byte (0xFF = none) |
| rsp_word | output | 32 | Trailer word for R3/R7 |
| rsp_status | output | 3 | Classified status |

## Verification
The assertions assume a shifter that keeps `xchg_ready` low whenever no byte is offered, and a host that holds its request fields steady while `req_valid` is high. The bench meets both conditions. Its shifter model answers only pending bytes, with a stall of one to three cycles, and it presents requests only while the engine is idle. Card replies come from a scripted queue that idle-returns 0xFF. The bench checks the byte stream against expected bytes built from the frame, poll and release rules.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_NORSP   = 3'd1,
    ST_CRC     = 3'd2,
    ST_ILLEGAL = 3'd3,
    ST_ERASE   = 3'd4,
    ST_PARAM   = 3'd5
  } stat_e;

  localparam logic [1:0] RT_R1  = 2'd0;
  localparam logic [1:0] RT_R1B = 2'd1;
  localparam logic [1:0] RT_R3  = 2'd2;
  localparam logic [1:0] RT_R7  = 2'd3;

  localparam logic [7:0] FILL = 8'hFF;

  function automatic logic is_fatal(stat_e s);
    return (s == ST_NORSP) || (s == ST_CRC) || (s == ST_ILLEGAL);
  endfunction
endpackage

// File: rtl/sdc_frame.sv
module sdc_frame (
  input  logic [5:0]  idx,
  input  logic [31:0] arg,
  input  logic [2:0]  pos,
  output logic [7:0]  tx_o
);
  logic [7:0] tail;

  always_comb begin
    if (idx == 6'd0)      tail = 8'h95;
    else if (idx == 6'd8) tail = 8'h87;
    else                  tail = 8'hFF;
  end

  always_comb begin
    case (pos)
      3'd0:    tx_o = {2'b01, idx};
      3'd1:    tx_o = arg[31:24];
      3'd2:    tx_o = arg[23:16];
      3'd3:    tx_o = arg[15:8];
      3'd4:    tx_o = arg[7:0];
      default: tx_o = tail;
    endcase
  end
endmodule

// File: rtl/sdc_classify.sv
module sdc_classify
  import sdc_pkg::*;
(
  input  logic [7:0] r1,
  output stat_e      stat
);
  always_comb begin
    if (r1 == 8'hFF)            stat = ST_NORSP;
    else if (r1[3])             stat = ST_CRC;
    else if (r1[2])             stat = ST_ILLEGAL;
    else if (r1[1] || r1[4])    stat = ST_ERASE;
    else if (r1[5] || r1[6])    stat = ST_PARAM;
    else                        stat = ST_OK;
  end
endmodule

// File: rtl/sdc_cmd_engine.sv
module sdc_cmd_engine
  import sdc_pkg::*;
#(
  parameter int POLL_MAX    = 16,
  parameter int RETRIES     = 3,
  parameter int READY_POLLS = 64,
  parameter int BUSY_POLLS  = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [5:0]  req_idx,
  input  logic [31:0] req_arg,
  input  logic        req_app,
  input  logic [1:0]  req_rtype,
  output logic        xchg_valid,
  input  logic        xchg_ready,
  output logic [7:0]  xchg_tx,
  input  logic [7:0]  xchg_rx,
  output logic        cs_n,
  output logic        done,
  output logic [7:0]  rsp_r1,
  output logic [31:0] rsp_word,
  output logic [2:0]  rsp_status
);
  localparam int MAXA  = (READY_POLLS > BUSY_POLLS) ? READY_POLLS : BUSY_POLLS;
  localparam int MAXP  = (MAXA > POLL_MAX) ? MAXA : POLL_MAX;
  localparam int CNT_W = $clog2(MAXP) + 1;
  localparam int TRY_W = $clog2(RETRIES) + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_READY, S_SEND, S_STUFF, S_POLL, S_APPW, S_TAIL, S_BUSY, S_REL, S_DONE
  } state_e;

  state_e            st;
  logic [5:0]        idx_q;
  logic [31:0]       arg_q;
  logic              app_q, pre_q, keep_q;
  logic [1:0]        rtype_q;
  logic [2:0]        pos;
  logic [CNT_W-1:0]  cnt;
  logic [TRY_W-1:0]  tries;
  logic [7:0]        r1_q;
  logic [31:0]       word_q;
  stat_e             stat_q;
  logic              cs_n_q;

  logic [7:0]  frame_byte;
  logic [7:0]  poll_byte;
  stat_e       stat_w;
  stat_e       stat_sel;
  logic        xfer, fin_keep, poll_end;

  sdc_frame u_frame (
    .idx  (pre_q ? 6'd55 : idx_q),
    .arg  (pre_q ? 32'd0 : arg_q),
    .pos  (pos),
    .tx_o (frame_byte)
  );

  assign poll_byte = xchg_rx[7] ? FILL : xchg_rx;

  sdc_classify u_cls (
    .r1   (poll_byte),
    .stat (stat_w)
  );

  assign xchg_valid = (st != S_IDLE) && (st != S_DONE);
  assign xchg_tx    = (st == S_SEND) ? frame_byte : FILL;
  assign xfer       = xchg_valid && xchg_ready;
  assign req_ready  = (st == S_IDLE);
  assign done       = (st == S_DONE);
  assign cs_n       = cs_n_q;
  assign rsp_r1     = r1_q;
  assign rsp_word   = word_q;
  assign rsp_status = stat_q;
  assign stat_sel   = (st == S_POLL) ? stat_w : stat_q;
  assign fin_keep   = keep_q && (stat_sel == ST_OK);
  assign poll_end   = !xchg_rx[7] || (cnt == CNT_W'(POLL_MAX - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx_q   <= '0;
      arg_q   <= '0;
      app_q   <= 1'b0;
      pre_q   <= 1'b0;
      keep_q  <= 1'b0;
      rtype_q <= RT_R1;
      pos     <= '0;
      cnt     <= '0;
      tries   <= '0;
      r1_q    <= '0;
      word_q  <= '0;
      stat_q  <= ST_OK;
      cs_n_q  <= 1'b1;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          idx_q   <= req_idx;
          arg_q   <= req_arg;
          app_q   <= req_app;
          rtype_q <= req_rtype;
          keep_q  <= (!req_app && (req_idx == 6'd9 || req_idx == 6'd17 || req_idx == 6'd18 ||
                                   req_idx == 6'd24 || req_idx == 6'd25)) ||
                     (req_app && req_idx == 6'd22);
          word_q  <= '0;
          r1_q    <= FILL;
          stat_q  <= ST_OK;
          cs_n_q  <= 1'b0;
          tries   <= '0;
          cnt     <= '0;
          pos     <= '0;
          pre_q   <= req_app;
          st      <= (req_idx == 6'd12) ? S_SEND : S_READY;
        end
        S_READY, S_APPW: if (xfer) begin
          if (xchg_rx == FILL || cnt == CNT_W'(READY_POLLS - 1)) begin
            cnt <= '0;
            pos <= '0;
            if (st == S_APPW) pre_q <= 1'b0;
            st  <= S_SEND;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SEND: if (xfer) begin
          if (pos == 3'd5) begin
            pos <= '0;
            cnt <= '0;
            st  <= (!pre_q && idx_q == 6'd12) ? S_STUFF : S_POLL;
          end else begin
            pos <= pos + 1'b1;
          end
        end
        S_STUFF: if (xfer) begin
          cnt <= '0;
          st  <= S_POLL;
        end
        S_POLL: if (xfer) begin
          if (!poll_end) begin
            cnt <= cnt + 1'b1;
          end else if (pre_q) begin
            cnt <= '0;
            st  <= S_APPW;
          end else if (poll_byte == FILL && tries != TRY_W'(RETRIES - 1)) begin
            tries <= tries + 1'b1;
            pos   <= '0;
            pre_q <= app_q;
            st    <= S_SEND;
          end else begin
            r1_q   <= poll_byte;
            stat_q <= stat_w;
            cnt    <= '0;
            if (is_fatal(stat_w)) begin
              cs_n_q <= 1'b1;
              st     <= S_REL;
            end else if (rtype_q == RT_R3 || rtype_q == RT_R7) begin
              st <= S_TAIL;
            end else if (rtype_q == RT_R1B) begin
              st <= S_BUSY;
            end else if (fin_keep) begin
              st <= S_DONE;
            end else begin
              cs_n_q <= 1'b1;
              st     <= S_REL;
            end
          end
        end
        S_TAIL, S_BUSY: if (xfer) begin
          if (st == S_TAIL) word_q <= {word_q[23:0], xchg_rx};
          if ((st == S_TAIL && cnt == CNT_W'(3)) ||
              (st == S_BUSY && (xchg_rx == FILL || cnt == CNT_W'(BUSY_POLLS - 1)))) begin
            cnt <= '0;
            if (fin_keep) begin
              st <= S_DONE;
            end else begin
              cs_n_q <= 1'b1;
              st     <= S_REL;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_REL: if (xfer) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdc_cmd_engine_chk.sv
module sdc_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        xchg_valid,
  input logic        xchg_ready,
  input logic [7:0]  xchg_tx,
  input logic        cs_n,
  input logic        done,
  input logic [7:0]  rsp_r1,
  input logic [2:0]  rsp_status
);
  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_valid && !xchg_ready |=> xchg_valid && $stable(xchg_tx));

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !xchg_valid);

  // R11
  keep_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !cs_n |-> rsp_status == 3'd0);

  // R8
  norsp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && rsp_r1 == 8'hFF |-> rsp_status == 3'd1);

  // R3
  r1_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && rsp_status != 3'd1 |-> !rsp_r1[7]);
endmodule

bind sdc_cmd_engine sdc_cmd_engine_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .xchg_valid (xchg_valid),
  .xchg_ready (xchg_ready),
  .xchg_tx    (xchg_tx),
  .cs_n       (cs_n),
  .done       (done),
  .rsp_r1     (rsp_r1),
  .rsp_status (rsp_status)
);

// File: tb/sdc_cmd_engine_tb.sv
module sdc_cmd_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_idx = '0;
  logic [31:0] req_arg = '0;
  logic        req_app = 1'b0;
  logic [1:0]  req_rtype = '0;
  logic        xchg_valid;
  logic        xchg_ready = 1'b0;
  logic [7:0]  xchg_tx;
  logic [7:0]  xchg_rx = 8'hFF;
  logic        cs_n;
  logic        done;
  logic [7:0]  rsp_r1;
  logic [31:0] rsp_word;
  logic [2:0]  rsp_status;

  int vectors = 0;
  int bad = 0;
  int cycles = 0;
  int wcnt = 0;
  int nbytes = 0;
  byte unsigned exp_tx[$];
  bit           exp_cs[$];
  byte unsigned rxq[$];
  string        tag = "R1";

  always #10 clk = ~clk;

  sdc_cmd_engine #(.READY_POLLS(6), .BUSY_POLLS(6)) u_dut (.*);

  task automatic chk(input string r, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  // shifter model: compares every exchanged byte against the expected stream
  always @(negedge clk) begin
    cycles++;
    if (xchg_ready) begin
      xchg_ready <= 1'b0;
      wcnt <= 0;
    end else if (xchg_valid) begin
      if (wcnt >= (nbytes % 3)) begin
        nbytes++;
        if (exp_tx.size() == 0) begin
          chk(tag, "unexpected byte", xchg_tx, 9'h100);
        end else begin
          chk(tag, "tx byte", xchg_tx, exp_tx.pop_front());
          chk("R11", "cs_n during byte", cs_n, exp_cs.pop_front());
        end
        xchg_rx <= (rxq.size() != 0) ? rxq.pop_front() : 8'hFF;
        xchg_ready <= 1'b1;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end

  task automatic ex(input byte unsigned rx);
    exp_tx.push_back(8'hFF); exp_cs.push_back(1'b0); rxq.push_back(rx);
  endtask

  task automatic rel();
    exp_tx.push_back(8'hFF); exp_cs.push_back(1'b1); rxq.push_back(8'hFF);
  endtask

  task automatic pkt(input logic [5:0] idx, input logic [31:0] arg);
    byte unsigned crc;
    crc = (idx == 0) ? 8'h95 : (idx == 8) ? 8'h87 : 8'hFF;
    exp_tx.push_back({2'b01, idx}); exp_tx.push_back(arg[31:24]); exp_tx.push_back(arg[23:16]);
    exp_tx.push_back(arg[15:8]); exp_tx.push_back(arg[7:0]); exp_tx.push_back(crc);
    for (int i = 0; i < 6; i++) begin exp_cs.push_back(1'b0); rxq.push_back(8'hFF); end
  endtask

  task automatic run(input string r, input logic [5:0] idx, input logic [31:0] arg, input bit app,
                     input logic [1:0] rt, input byte unsigned e_r1, input logic [31:0] e_word,
                     input int e_st, input bit e_cs);
    int t;
    tag = r;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_idx = idx; req_arg = arg; req_app = app; req_rtype = rt;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    chk(r, "done seen", done, 1);
    chk(r, "stream consumed", exp_tx.size(), 0);
    chk(r, "rsp_r1", rsp_r1, e_r1);
    chk(r, "rsp_word", rsp_word, e_word);
    chk("R8", "rsp_status", rsp_status, e_st);
    chk("R11", "cs_n at done", cs_n, e_cs);
    @(negedge clk);
    chk("R13", "done one cycle", done, 0);
    chk("R13", "result held", rsp_r1, e_r1);
    exp_tx.delete(); exp_cs.delete(); rxq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13", "reset req_ready", req_ready, 1);
    chk("R11", "reset cs_n", cs_n, 1);
    chk("R13", "reset done", done, 0);
    chk("R12", "reset xchg_valid", xchg_valid, 0);

    // R1 R2 R3: CMD0 framing, reply after two fill bytes
    ex(8'hFF); pkt(0, 0); ex(8'hFF); ex(8'hFF); ex(8'h01); rel();
    run("R2", 0, 0, 0, 2'd0, 8'h01, 0, 0, 1);

    // R9: CMD8 with trailer
    ex(8'hFF); pkt(8, 32'h1AA); ex(8'h01); ex(8'h00); ex(8'h00); ex(8'h01); ex(8'hAA); rel();
    run("R9", 8, 32'h1AA, 0, 2'd3, 8'h01, 32'h1AA, 0, 1);

    // R6 R11: busy before send, read command keeps select
    ex(8'h00); ex(8'h00); ex(8'hFF); pkt(17, 32'h200); ex(8'h00);
    run("R6", 17, 32'h200, 0, 2'd0, 8'h00, 0, 0, 0);

    // R5: application command prefix
    ex(8'hFF); pkt(55, 0); ex(8'h01); ex(8'hFF); pkt(41, 32'h4000_0000); ex(8'h00); rel();
    run("R5", 41, 32'h4000_0000, 1, 2'd0, 8'h00, 0, 0, 1);

    // R4: no response over three attempts
    ex(8'hFF);
    for (int a = 0; a < 3; a++) begin
      pkt(16, 32'h200);
      for (int i = 0; i < 16; i++) ex(8'hFF);
    end
    rel();
    run("R4", 16, 32'h200, 0, 2'd0, 8'hFF, 0, 1, 1);

    // R7 R10: stop command, stuff byte, busy
    pkt(12, 0); ex(8'h00); ex(8'h00); ex(8'h00); ex(8'h00); ex(8'hFF); rel();
    run("R7", 12, 0, 0, 2'd1, 8'h00, 0, 0, 1);

    // R8: illegal on CMD8, no trailer read
    ex(8'hFF); pkt(8, 32'h1AA); ex(8'h05); rel();
    run("R8", 8, 32'h1AA, 0, 2'd3, 8'h05, 0, 3, 1);

    // R8: CRC beats illegal
    ex(8'hFF); pkt(16, 32'h200); ex(8'h0C); rel();
    run("R8", 16, 32'h200, 0, 2'd0, 8'h0C, 0, 2, 1);

    // R8: erase beats address
    ex(8'hFF); pkt(32, 32'h10); ex(8'h22); rel();
    run("R8", 32, 32'h10, 0, 2'd0, 8'h22, 0, 4, 1);

    // R8 R11: parameter error on write releases select
    ex(8'hFF); pkt(24, 32'h400); ex(8'h40); rel();
    run("R11", 24, 32'h400, 0, 2'd0, 8'h40, 0, 5, 1);

    // R6 R3: ready timeout, bit-7-set byte skipped
    for (int i = 0; i < 6; i++) ex(8'h00);
    pkt(9, 0); ex(8'hC1); ex(8'h00);
    run("R3", 9, 0, 0, 2'd0, 8'h00, 0, 0, 0);

    // R4 R9: second attempt succeeds, R3 trailer
    ex(8'hFF); pkt(58, 0);
    for (int i = 0; i < 16; i++) ex(8'hFF);
    pkt(58, 0); ex(8'hFF); ex(8'h00); ex(8'hC0); ex(8'hFF); ex(8'h80); ex(8'h00); rel();
    run("R4", 58, 0, 0, 2'd2, 8'h00, 32'hC0FF_8000, 0, 1);

    // R11 R5: application 22 keeps select
    ex(8'hFF); pkt(55, 0); ex(8'h01); ex(8'hFF); pkt(22, 0); ex(8'h00);
    run("R11", 22, 0, 1, 2'd0, 8'h00, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end
endmodule